// File: doc/BRIEF.md
# Transport Packet Sync and Error-Flag Inserter

This block sits on a byte stream of fixed-length transport packets and finds where each packet begins. Packet boundaries come from one of two sources. In pulse mode an external frame-start level marks the first byte of a packet. In search mode the block hunts for a programmable sync byte and then checks that it recurs at a programmable packet spacing. Once boundaries are known, the block can overwrite the first byte of every packet with the configured sync value. The first packet of each group of eight gets the bitwise inverse of that value.

An upstream error flag is sampled together with the first byte of a packet. When it is high, the most significant bit of the packet's second byte is forced high, which is the transport error indicator. A sticky error-store bit is also set, and it can raise an interrupt request. A falling edge on the sequence-start input restarts the group-of-eight count. The packet that carries the restart is marked on a first-of-sequence output.

Each accepted byte appears on the output one clock later, alongside a frame-start marker and a lock indication.

Top module: `tsp_sync_flag_inserter`

## Requirements
- R1: While reset is asserted, out_valid, out_fstart, out_first, out_lock, err_store and irq are all 0.
- R2: A byte is taken only on a clock edge where in_valid is 1. It appears on out_byte, with out_valid at 1, one clock later, unchanged unless R4 or R5 applies. out_valid is 0 in a cycle after in_valid was 0.
- R3: With cfg_search at 0 (pulse mode), every accepted byte with in_fstart at 1 is a packet start and no other byte is. Both out_lock and out_fstart stay 0.
- R4: With cfg_insert at 1, the output byte at every packet start is replaced by cfg_sync, or by ~cfg_sync when the packet is first in its group of eight. Counting starts at reset: the first packet start after reset is inverted, then every eighth one. With cfg_insert at 0 the start byte passes unchanged.
- R5: in_err is sampled with the start byte. If it is 1, bit 7 of the next accepted byte that is not itself a start is forced to 1, and err_store becomes 1 and stays 1 until reset.
- R6: irq equals err_store AND cfg_irq_en.
- R7: A falling edge of in_seqstart is in_seqstart at 1 on one clock edge and at 0 on the next. It makes the first packet start on a later edge an inverted-sync packet and restarts the group of eight from it. out_first is 1 in the output cycle of exactly that packet's start byte.
- R8: With cfg_search at 1, an accepted byte equal to cfg_sync ends the hunt. out_lock goes to 1 after max(cfg_lock_thr,1) sync bytes, each exactly cfg_pkt_len accepted bytes after the previous one. A missing sync at an expected position before lock returns to hunting.
- R9: While locked, every cfg_pkt_len-th accepted byte is a packet start, whether it matches or not. A match raises a confidence count, capped at the threshold. A mismatch lowers it, and out_lock falls when it reaches 0. The bytes of the acquisition phase are not starts.
- R10: In search mode out_fstart is 1 for 1+cfg_gap consecutive cycles from the output cycle of a start byte. A new start reloads the count.
- R11: While in_valid is 0, packet position, lock state and confidence do not change, so stalls never shift a packet boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_search | input | 1 | 1 = find boundaries by sync search, 0 = frame-start pulse |
| cfg_insert | input | 1 | Enable sync byte rewriting |
| cfg_sync | input | 8 | Sync byte value |
| cfg_pkt_len | input | LEN_W | Packet length in bytes (at least 2) |
| cfg_lock_thr | input | CONF_W | Sync bytes needed for lock, 0 treated as 1 |
| cfg_gap | input | GAP_W | Extra frame-start cycles (check-byte gaps) |
| cfg_irq_en | input | 1 | Interrupt enable for the error-store bit |
| in_byte | input | 8 | Input byte |
| in_valid | input | 1 | Input byte valid |
| in_fstart | input | 1 | Frame-start marker for pulse mode |
| in_seqstart | input | 1 | Sequence restart, acts on its falling edge |
| in_err | input | 1 | Upstream uncorrectable-error flag |
| out_byte | output | 8 | Output byte |
| out_valid | output | 1 | Output byte valid |
| out_fstart | output | 1 | Packet start marker, search mode only |
| out_first | output | 1 | First packet after a sequence restart |
| out_lock | output | 1 | Search-mode lock indication |
| err_store | output | 1 | Sticky error seen |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach is loss of lock from a saturated confidence count. Lock must first be won with correctly spaced sync bytes. Then a lone corrupted sync must be shown not to drop it, and a run of as many corrupted sync bytes as the threshold must drop it, all while random stalls move the cycle positions. The stimulus reaches this with directed packet sequences whose sync byte is good or deliberately bit-flipped, and with random payload that never equals the sync value. A cycle-level model in the bench tracks the expected boundary, confidence and inversion count. A sequence-start pulse is also placed on the last byte of a packet, so its falling edge coincides with the next start and must defer the restart by one packet.

// File: rtl/tsfi_pkg.sv
package tsfi_pkg;
   typedef enum logic [1:0] {
      ALN_HUNT = 2'd0,
      ALN_ACQ  = 2'd1,
      ALN_LOCK = 2'd2
   } aln_state_e;
endpackage

// File: rtl/tsfi_align.sv
module tsfi_align
   import tsfi_pkg::*;
#(
   parameter int LEN_W  = 8,
   parameter int CONF_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_search,
   input  logic [7:0]        cfg_sync,
   input  logic [LEN_W-1:0]  cfg_len,
   input  logic [CONF_W-1:0] cfg_thr,
   input  logic              in_valid,
   input  logic [7:0]        in_byte,
   input  logic              in_fstart,
   output logic              start_evt,
   output logic              locked
);
   aln_state_e        st, st_n;
   logic [LEN_W-1:0]  pos, pos_n, pos_adv;
   logic [CONF_W-1:0] conf, conf_n, thr;
   logic              hit, at_bnd;

   assign thr     = (cfg_thr == '0) ? CONF_W'(1) : cfg_thr;
   assign hit     = (in_byte == cfg_sync);
   assign at_bnd  = (pos == '0);
   assign pos_adv = (pos >= cfg_len - LEN_W'(1)) ? '0 : pos + LEN_W'(1);

   always_comb begin
      st_n   = st;
      pos_n  = pos;
      conf_n = conf;
      if (!cfg_search) begin
         st_n   = ALN_HUNT;
         conf_n = '0;
      end else if (in_valid) begin
         case (st)
            ALN_HUNT: begin
               if (hit) begin
                  conf_n = CONF_W'(1);
                  pos_n  = (cfg_len > LEN_W'(1)) ? LEN_W'(1) : '0;
                  st_n   = (thr == CONF_W'(1)) ? ALN_LOCK : ALN_ACQ;
               end
            end
            ALN_ACQ: begin
               pos_n = pos_adv;
               if (at_bnd) begin
                  if (hit) begin
                     conf_n = conf + CONF_W'(1);
                     if ((conf + CONF_W'(1)) >= thr) st_n = ALN_LOCK;
                  end else begin
                     conf_n = '0;
                     st_n   = ALN_HUNT;
                  end
               end
            end
            ALN_LOCK: begin
               pos_n = pos_adv;
               if (at_bnd) begin
                  if (hit) begin
                     conf_n = (conf >= thr) ? thr : conf + CONF_W'(1);
                  end else if (conf <= CONF_W'(1)) begin
                     conf_n = '0;
                     st_n   = ALN_HUNT;
                  end else begin
                     conf_n = conf - CONF_W'(1);
                  end
               end
            end
            default: st_n = ALN_HUNT;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ALN_HUNT;
         pos  <= '0;
         conf <= '0;
      end else begin
         st   <= st_n;
         pos  <= pos_n;
         conf <= conf_n;
      end
   end

   assign start_evt = cfg_search ? (in_valid && st == ALN_LOCK && at_bnd)
                                 : (in_valid && in_fstart);
   assign locked    = (st == ALN_LOCK);

   p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && cfg_search) |=> ($stable(pos) && $stable(st) && $stable(conf)));
   p_pulse_nolock_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_search |=> (st == ALN_HUNT));
   p_lock_conf_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ALN_LOCK) |-> (conf != '0));
endmodule

// File: rtl/tsfi_seq.sv
module tsfi_seq #(
   parameter int SEQ_PERIOD = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_seqstart,
   input  logic start_evt,
   output logic invert,
   output logic first
);
   localparam int SEQ_W = (SEQ_PERIOD > 1) ? $clog2(SEQ_PERIOD) : 1;

   logic [SEQ_W-1:0] cnt, base, nxt;
   logic             pend, ss_d, fall;

   assign fall   = ss_d && !in_seqstart;
   assign base   = pend ? '0 : cnt;
   assign invert = (base == '0);
   assign first  = start_evt && pend;

   generate
      if ((SEQ_PERIOD & (SEQ_PERIOD - 1)) == 0) begin : g_pow2
         assign nxt = base + SEQ_W'(1);
      end else begin : g_mod
         assign nxt = (base == SEQ_W'(SEQ_PERIOD - 1)) ? '0 : base + SEQ_W'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         pend <= 1'b0;
         ss_d <= 1'b0;
      end else begin
         ss_d <= in_seqstart;
         if (start_evt) cnt <= nxt;
         if (fall) pend <= 1'b1;
         else if (start_evt) pend <= 1'b0;
      end
   end

   p_restart_cnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (start_evt && pend) |=> (cnt == SEQ_W'(1)));
   p_fall_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ss_d && !in_seqstart) |=> pend);
endmodule

// File: rtl/tsfi_rewrite.sv
module tsfi_rewrite #(
   parameter int GAP_W   = 5,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_insert,
   input  logic             cfg_search,
   input  logic [7:0]       cfg_sync,
   input  logic [GAP_W-1:0] cfg_gap,
   input  logic             cfg_irq_en,
   input  logic             in_valid,
   input  logic [7:0]       in_byte,
   input  logic             in_err,
   input  logic             start_evt,
   input  logic             invert,
   input  logic             first,
   output logic [7:0]       out_byte,
   output logic             out_valid,
   output logic             out_fstart,
   output logic             out_first,
   output logic             err_store,
   output logic             irq
);
   logic [7:0]       wr;
   logic             hdr_err, fs_q;
   logic [GAP_W-1:0] fs_rem;

   always_comb begin
      wr = in_byte;
      if (start_evt && cfg_insert) wr = invert ? ~cfg_sync : cfg_sync;
      else if (!start_evt && hdr_err) wr[7] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_byte  <= '0;
         out_valid <= 1'b0;
         out_first <= 1'b0;
         hdr_err   <= 1'b0;
         err_store <= 1'b0;
         fs_q      <= 1'b0;
         fs_rem    <= '0;
      end else begin
         out_valid <= in_valid;
         out_first <= first;
         if (in_valid) begin
            out_byte <= wr;
            hdr_err  <= start_evt && in_err;
         end
         if (start_evt && in_err) err_store <= 1'b1;
         if (start_evt && cfg_search) begin
            fs_q   <= 1'b1;
            fs_rem <= cfg_gap;
         end else if (fs_rem != '0) begin
            fs_q   <= 1'b1;
            fs_rem <= fs_rem - GAP_W'(1);
         end else begin
            fs_q <= 1'b0;
         end
      end
   end

   assign out_fstart = fs_q;

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= (err_store || (start_evt && in_err)) && cfg_irq_en;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = err_store && cfg_irq_en;
      end
   endgenerate

   p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      err_store |=> err_store);
   p_hdr_mark_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && hdr_err && !start_evt) |=> out_byte[7]);
   p_irq_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> err_store);
   p_fs_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fs_q) |-> $past(cfg_search));
   p_first_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_first |-> out_valid);
endmodule

// File: rtl/tsp_sync_flag_inserter.sv
module tsp_sync_flag_inserter #(
   parameter int LEN_W      = 8,
   parameter int CONF_W     = 4,
   parameter int GAP_W      = 5,
   parameter int SEQ_PERIOD = 8,
   parameter bit IRQ_REG    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_search,
   input  logic              cfg_insert,
   input  logic [7:0]        cfg_sync,
   input  logic [LEN_W-1:0]  cfg_pkt_len,
   input  logic [CONF_W-1:0] cfg_lock_thr,
   input  logic [GAP_W-1:0]  cfg_gap,
   input  logic              cfg_irq_en,
   input  logic [7:0]        in_byte,
   input  logic              in_valid,
   input  logic              in_fstart,
   input  logic              in_seqstart,
   input  logic              in_err,
   output logic [7:0]        out_byte,
   output logic              out_valid,
   output logic              out_fstart,
   output logic              out_first,
   output logic              out_lock,
   output logic              err_store,
   output logic              irq
);
   generate
      if (LEN_W < 2) begin : g_bad_len
         $error("LEN_W must be at least 2");
      end
      if (CONF_W < 1) begin : g_bad_conf
         $error("CONF_W must be at least 1");
      end
      if (GAP_W < 1) begin : g_bad_gap
         $error("GAP_W must be at least 1");
      end
      if (SEQ_PERIOD < 2) begin : g_bad_seq
         $error("SEQ_PERIOD must be at least 2");
      end
   endgenerate

   logic start_evt, invert, first;

   tsfi_align #(.LEN_W(LEN_W), .CONF_W(CONF_W)) u_align (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_search(cfg_search),
      .cfg_sync  (cfg_sync),
      .cfg_len   (cfg_pkt_len),
      .cfg_thr   (cfg_lock_thr),
      .in_valid  (in_valid),
      .in_byte   (in_byte),
      .in_fstart (in_fstart),
      .start_evt (start_evt),
      .locked    (out_lock)
   );

   tsfi_seq #(.SEQ_PERIOD(SEQ_PERIOD)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_seqstart(in_seqstart),
      .start_evt  (start_evt),
      .invert     (invert),
      .first      (first)
   );

   tsfi_rewrite #(.GAP_W(GAP_W), .IRQ_REG(IRQ_REG)) u_rewrite (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_insert(cfg_insert),
      .cfg_search(cfg_search),
      .cfg_sync  (cfg_sync),
      .cfg_gap   (cfg_gap),
      .cfg_irq_en(cfg_irq_en),
      .in_valid  (in_valid),
      .in_byte   (in_byte),
      .in_err    (in_err),
      .start_evt (start_evt),
      .invert    (invert),
      .first     (first),
      .out_byte  (out_byte),
      .out_valid (out_valid),
      .out_fstart(out_fstart),
      .out_first (out_first),
      .err_store (err_store),
      .irq       (irq)
   );

   p_rst_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!out_valid && !err_store));
   p_nolock_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_search |=> !out_lock);
endmodule

// File: tb/tb_tsp_sync_flag_inserter.sv
module tb_tsp_sync_flag_inserter;
   localparam int CLK_PERIOD = 10;
   localparam int LEN_W = 8, CONF_W = 4, GAP_W = 5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_search = 0, cfg_insert = 0, cfg_irq_en = 0;
   logic [7:0] cfg_sync = 8'h47;
   logic [LEN_W-1:0] cfg_pkt_len = 8'd204;
   logic [CONF_W-1:0] cfg_lock_thr = 4'd3;
   logic [GAP_W-1:0] cfg_gap = '0;
   logic [7:0] in_byte = '0;
   logic in_valid = 0, in_fstart = 0, in_seqstart = 0, in_err = 0;
   logic [7:0] out_byte;
   logic out_valid, out_fstart, out_first, out_lock, err_store, irq;

   tsp_sync_flag_inserter dut (
      .clk(clk), .rst_n(rst_n), .cfg_search(cfg_search), .cfg_insert(cfg_insert),
      .cfg_sync(cfg_sync), .cfg_pkt_len(cfg_pkt_len), .cfg_lock_thr(cfg_lock_thr),
      .cfg_gap(cfg_gap), .cfg_irq_en(cfg_irq_en), .in_byte(in_byte), .in_valid(in_valid),
      .in_fstart(in_fstart), .in_seqstart(in_seqstart), .in_err(in_err),
      .out_byte(out_byte), .out_valid(out_valid), .out_fstart(out_fstart),
      .out_first(out_first), .out_lock(out_lock), .err_store(err_store), .irq(irq));

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0, n_fail = 0;
   // configuration applied at the next step
   bit n_search = 0, n_insert = 1, n_irq = 0;
   int n_sync = 8'h47, n_len = 12, n_thr = 3, n_gap = 0;
   // reference model state
   int m_pos = 0, m_st = 0, m_conf = 0, m_cnt = 0, m_fs_rem = 0;
   bit m_pend = 0, m_ssd = 0, m_hdr = 0, m_es = 0, m_fs = 0;
   bit e_valid = 0, e_first = 0, e_lock = 0, e_irq = 0;
   logic [7:0] e_byte = '0;
   string e_btag = "R2";
   string lk_tag = "R3";

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic check_outputs();
      chk(out_valid === e_valid, "R11", "out_valid", out_valid, e_valid);
      if (e_valid) chk(out_byte === e_byte, e_btag, "out_byte", out_byte, e_byte);
      chk(out_first === e_first, "R7", "out_first", out_first, e_first);
      chk(out_fstart === m_fs, n_search ? "R10" : "R3", "out_fstart", out_fstart, m_fs);
      chk(out_lock === e_lock, lk_tag, "out_lock", out_lock, e_lock);
      chk(err_store === m_es, "R5", "err_store", err_store, m_es);
      chk(irq === e_irq, "R6", "irq", irq, e_irq);
   endtask

   task automatic step(input bit v, input logic [7:0] b, input bit fs,
                       input bit er, input bit ss);
      int thr, pos_adv;
      bit start, hit, atb, inv, fall;
      @(negedge clk);
      check_outputs();
      cfg_search = n_search; cfg_insert = n_insert; cfg_irq_en = n_irq;
      cfg_sync = n_sync[7:0]; cfg_pkt_len = n_len[LEN_W-1:0];
      cfg_lock_thr = n_thr[CONF_W-1:0]; cfg_gap = n_gap[GAP_W-1:0];
      in_valid = v; in_byte = b; in_fstart = fs; in_err = er; in_seqstart = ss;
      thr = (n_thr == 0) ? 1 : n_thr;
      start = 0;
      hit = (b == n_sync[7:0]);
      atb = (m_pos == 0);
      pos_adv = (m_pos >= n_len - 1) ? 0 : m_pos + 1;
      if (!n_search) begin
         start = v && fs; m_st = 0; m_conf = 0;
      end else if (v) begin
         case (m_st)
            0: if (hit) begin
                  m_conf = 1; m_pos = (n_len > 1) ? 1 : 0; m_st = (thr == 1) ? 2 : 1;
               end
            1: begin
                  m_pos = pos_adv;
                  if (atb) begin
                     if (hit) begin m_conf++; if (m_conf >= thr) m_st = 2; end
                     else begin m_st = 0; m_conf = 0; end
                  end
               end
            default: begin
                  start = atb; m_pos = pos_adv;
                  if (atb) begin
                     if (hit) m_conf = (m_conf >= thr) ? thr : m_conf + 1;
                     else if (m_conf <= 1) begin m_st = 0; m_conf = 0; end
                     else m_conf--;
                  end
               end
         endcase
      end
      inv = m_pend || (m_cnt == 0);
      e_valid = v;
      e_first = start && m_pend;
      if (v) begin
         e_byte = b; e_btag = "R2";
         if (start && n_insert) begin
            e_byte = inv ? ~n_sync[7:0] : n_sync[7:0]; e_btag = "R4";
         end else if (!start && m_hdr) begin
            e_byte[7] = 1'b1; e_btag = "R5";
         end
         m_hdr = start && er;
      end
      if (start && er) m_es = 1;
      if (start) m_cnt = ((m_pend ? 0 : m_cnt) + 1) % 8;
      fall = m_ssd && !ss;
      if (fall) m_pend = 1; else if (start) m_pend = 0;
      m_ssd = ss;
      if (start && n_search) begin m_fs = 1; m_fs_rem = n_gap; end
      else if (m_fs_rem != 0) begin m_fs = 1; m_fs_rem--; end
      else m_fs = 0;
      e_lock = (m_st == 2);
      e_irq = m_es && n_irq;
   endtask

   task automatic send_pkt(input int len, input bit good, input bit err,
                           input int ss_idx, input int stall_pct);
      for (int i = 0; i < len; i++) begin
         logic [7:0] b;
         b = 8'($urandom);
         if (b == n_sync[7:0]) b = b ^ 8'h01;
         if (i == 0) b = good ? n_sync[7:0] : (n_sync[7:0] ^ 8'h10);
         while (($urandom % 100) < stall_pct) step(0, 8'($urandom), 1'b1, 1'b1, 1'b0);
         step(1, b, i == 0, (i == 0) ? err : 1'($urandom), i == ss_idx);
      end
   endtask

   initial begin
      void'($urandom(32'h1c0de));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(out_valid === 0, "R1", "out_valid", out_valid, 0);
      chk(out_fstart === 0, "R1", "out_fstart", out_fstart, 0);
      chk(out_first === 0, "R1", "out_first", out_first, 0);
      chk(out_lock === 0, "R1", "out_lock", out_lock, 0);
      chk(err_store === 0, "R1", "err_store", err_store, 0);
      chk(irq === 0, "R1", "irq", irq, 0);
      rst_n = 1'b1;

      // pulse mode with insertion, stalls, errors and a sequence restart
      lk_tag = "R3";
      for (int p = 0; p < 12; p++)
         send_pkt(12, 1, (p % 3) == 1, (p == 5) ? 4 : ((p == 8) ? 11 : -1), 20);
      n_irq = 1;
      for (int p = 0; p < 3; p++) send_pkt(12, 1, 0, -1, 10);
      // pulse mode, insertion off: corrupted start bytes pass through
      n_insert = 0;
      for (int p = 0; p < 3; p++) send_pkt(10, 0, 1, -1, 0);
      n_insert = 1;

      // search mode: acquisition, single miss, loss of lock, reacquisition
      n_search = 1; n_len = 16; n_thr = 3; n_gap = 16; lk_tag = "R8";
      for (int p = 0; p < 6; p++) send_pkt(16, 1, p == 4, (p == 5) ? 3 : -1, 15);
      lk_tag = "R9";
      send_pkt(16, 0, 0, -1, 15);
      for (int p = 0; p < 2; p++) send_pkt(16, 1, 0, -1, 15);
      for (int p = 0; p < 3; p++) send_pkt(16, 0, 0, -1, 15);
      for (int p = 0; p < 2; p++) send_pkt(16, 1, 0, -1, 0);
      lk_tag = "R8";
      for (int p = 0; p < 5; p++) send_pkt(16, 1, 0, -1, 10);

      // threshold 0 acts as 1, default packet length, no gap
      n_thr = 0; n_gap = 0; n_len = 204; n_sync = 8'hb8;
      for (int p = 0; p < 4; p++) send_pkt(204, 1, p == 2, -1, 5);
      lk_tag = "R3";
      n_search = 0;
      send_pkt(8, 1, 0, -1, 0);
      step(0, 8'h00, 0, 0, 0);
      step(0, 8'h00, 0, 0, 0);
      @(negedge clk);
      check_outputs();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      chk(0, "R11", "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule